// File: doc/BRIEF.md
# Card Command Response Capture

This block runs one command exchange with a memory card at a time. A host writes an 11-bit command word and a 32-bit argument. When the start bit of that word is set, the block raises a one-cycle request on an abstract card port. The request carries the 6-bit command index and the argument. The card side then returns the response one byte per cycle and closes the exchange with a done strobe. It may flag an error on that same strobe.

On the done strobe the block counts the bytes it received and checks that count against the kind of response the command word asked for. It then does one of two things:

- If the count is valid, it packs the bytes into four 32-bit response words, most significant byte first.
- If the count is wrong, it leaves the response words as they were and raises a timeout.

Exactly one of three sticky status bits is set at completion: command sent, response received or timeout. In the same edge the start bit in the stored command word clears and the busy flag drops. A command write that arrives while an exchange is in flight is discarded. A byte presented in the same cycle as the done strobe is not counted.

Top module: `cmd_rsp_capture`

## Requirements
- R1: While idle, a write (`cmd_wr`) whose word has bit 10 (start) set makes `busy` high from the next cycle. In that cycle only, `req_valid` is high with `req_index` equal to word bits [5:0] and `req_arg` equal to the written argument.
- R2: While idle, a write with bit 10 clear stores the word in `cmd_word_o`, raises no request and leaves `busy` low.
- R3: When word bit 6 (expect response) is clear, completion without card error sets `status[7]` and leaves `resp_data` unchanged, whatever bytes arrived.
- R4: When bit 6 is set, a timeout is reported and `resp_data` is left unchanged if the byte count was 0, was 4 with word bit 7 (long) set, or was neither 4 nor 16. The timeout is `status[2]`. Counts above 16 are treated as invalid.
- R5: When bit 6 is set and the byte count is valid with no card error, `status[6]` is set.
- R6: Byte k of a valid response lands in word k/4, at bits [31-8*(k mod 4) -: 8]. Word w occupies `resp_data[32*w+31 : 32*w]`.
- R7: A valid 4-byte response clears words 1 to 3.
- R8: A 16-byte response is valid whether or not bit 7 is set, and bit 0 of word 3 (`resp_data[96]`) is forced to zero.
- R9: `rsp_err` high on the done strobe sets `status[2]` and leaves `resp_data` unchanged, even when the byte count is valid or no response was expected.
- R10: On the completion edge `busy` falls and `cmd_word_o[10]` clears. Bits [9:0] of `cmd_word_o` are kept.
- R11: A `cmd_wr` while `busy` is high changes neither `cmd_word_o` nor the argument and raises no new request.
- R12: Status bits are sticky. A bit is cleared by a 1 in the same position of `status_clr`, and a completion setting a bit in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word_i | input | 11 | Command word: index [5:0], expect response 6, long 7, 8 and 9 stored only, start 10 |
| cmd_arg_i | input | 32 | Command argument, taken with the word |
| status_clr | input | 8 | Per-bit clear of the status bits |
| req_valid | output | 1 | One-cycle request to the card |
| req_index | output | 6 | Command index of the request |
| req_arg | output | 32 | Argument of the request |
| rsp_byte_valid | input | 1 | Response byte present |
| rsp_byte | input | 8 | Response byte |
| rsp_done | input | 1 | End of the card's response |
| rsp_err | input | 1 | Card-side error, sampled with rsp_done |
| busy | output | 1 | Exchange in flight |
| cmd_word_o | output | 11 | Stored command word |
| status | output | 8 | Sticky status: 2 timeout, 6 response received, 7 command sent |
| resp_data | output | 128 | Four response words, word 0 in the low bits |

## Verification
The hardest states to reach are the invalid-length cases. Byte counts past the buffer end must saturate rather than wrap back to a valid value. A long request answered with a short response must be rejected while an identical short request is accepted. The stimulus sweeps every byte count from 0 to 18 against each combination of the expect and long bits, so both the counter saturation and the 4-with-long rejection are driven on purpose. It also checks each timeout against a response image that an earlier valid command deliberately left non-zero. Extra runs inject a second command write in mid-exchange and a status clear on the completion edge itself.

// File: rtl/cmd_rsp_pkg.sv
package cmd_rsp_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REQ  = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

    localparam int CW_W      = 11;
    localparam int CW_IDX_W  = 6;
    localparam int CW_RESP   = 6;
    localparam int CW_LONG   = 7;
    localparam int CW_START  = 10;

    localparam int STAT_W    = 8;
    localparam int ST_TOUT   = 2;
    localparam int ST_GOT    = 6;
    localparam int ST_SENT   = 7;
endpackage

// File: rtl/cr_byte_buf.sv
module cr_byte_buf #(
    parameter int LONG_BYTES = 16,
    parameter int CNT_W      = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr_en,
    input  logic [7:0]              wr_byte,
    output logic [CNT_W-1:0]        cnt,
    output logic [LONG_BYTES*8-1:0] bytes_o
);
    localparam int CNT_SAT = LONG_BYTES + 1;

    typedef struct packed {
        logic [CNT_W-1:0]            cnt;
        logic [LONG_BYTES-1:0][7:0]  mem;
    } buf_t;

    buf_t buf_d, buf_q;
    logic [LONG_BYTES-1:0] lane_we;

    generate
        for (genvar i = 0; i < LONG_BYTES; i++) begin : g_lane
            assign lane_we[i] = wr_en && !clr && (buf_q.cnt == CNT_W'(i));
        end
    endgenerate

    always_comb begin
        buf_d = buf_q;
        if (clr) begin
            buf_d.cnt = '0;
        end else if (wr_en && buf_q.cnt != CNT_W'(CNT_SAT)) begin
            buf_d.cnt = buf_q.cnt + 1'b1;
        end
        for (int i = 0; i < LONG_BYTES; i++) begin
            if (lane_we[i]) buf_d.mem[i] = wr_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign cnt     = buf_q.cnt;
    assign bytes_o = buf_q.mem;
endmodule

// File: rtl/cr_verdict.sv
module cr_verdict #(
    parameter int LONG_BYTES  = 16,
    parameter int SHORT_BYTES = 4,
    parameter int WORD_W      = 32,
    parameter int CNT_W       = 5
) (
    input  logic                    expect_rsp,
    input  logic                    long_rsp,
    input  logic                    card_err,
    input  logic [CNT_W-1:0]        cnt,
    input  logic [LONG_BYTES*8-1:0] bytes_i,
    output logic                    tout,
    output logic                    got_rsp,
    output logic                    sent,
    output logic [LONG_BYTES*8-1:0] words_o
);
    localparam int BPW    = WORD_W / 8;
    localparam int NWORDS = LONG_BYTES / BPW;

    logic [LONG_BYTES*8-1:0] packed_w;
    logic is_short, is_long, bad;

    generate
        for (genvar w = 0; w < NWORDS; w++) begin : g_word
            for (genvar j = 0; j < BPW; j++) begin : g_byte
                assign packed_w[w*WORD_W + WORD_W - 1 - 8*j -: 8] =
                    bytes_i[(w*BPW + j)*8 +: 8];
            end
        end
    endgenerate

    assign is_short = (cnt == CNT_W'(SHORT_BYTES));
    assign is_long  = (cnt == CNT_W'(LONG_BYTES));
    assign bad      = card_err ||
                      (expect_rsp && ((cnt == '0) || (is_short && long_rsp) ||
                                      !(is_short || is_long)));
    assign tout     = bad;
    assign got_rsp  = !bad && expect_rsp;
    assign sent     = !bad && !expect_rsp;

    always_comb begin
        words_o = packed_w;
        if (is_short) begin
            words_o[LONG_BYTES*8-1:SHORT_BYTES*8] = '0;
        end else begin
            words_o[(NWORDS-1)*WORD_W] = 1'b0;
        end
    end
endmodule

// File: rtl/cmd_rsp_capture.sv
module cmd_rsp_capture
    import cmd_rsp_pkg::*;
#(
    parameter int LONG_BYTES  = 16,
    parameter int SHORT_BYTES = 4,
    parameter int WORD_W      = 32,
    parameter int ARG_W       = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_wr,
    input  logic [CW_W-1:0]         cmd_word_i,
    input  logic [ARG_W-1:0]        cmd_arg_i,
    input  logic [STAT_W-1:0]       status_clr,
    output logic                    req_valid,
    output logic [CW_IDX_W-1:0]     req_index,
    output logic [ARG_W-1:0]        req_arg,
    input  logic                    rsp_byte_valid,
    input  logic [7:0]              rsp_byte,
    input  logic                    rsp_done,
    input  logic                    rsp_err,
    output logic                    busy,
    output logic [CW_W-1:0]         cmd_word_o,
    output logic [STAT_W-1:0]       status,
    output logic [LONG_BYTES*8-1:0] resp_data
);
    localparam int RESP_W = LONG_BYTES * 8;
    localparam int CNT_W  = $clog2(LONG_BYTES + 2);

    typedef struct packed {
        phase_e             phase;
        logic [CW_W-1:0]    cmd;
        logic [ARG_W-1:0]   arg;
        logic [STAT_W-1:0]  status;
        logic [RESP_W-1:0]  resp;
    } state_t;

    state_t st_d, st_q;

    logic              start;
    logic              byte_we;
    logic [CNT_W-1:0]  byte_cnt;
    logic [RESP_W-1:0] byte_img;
    logic              v_tout, v_got, v_sent;
    logic [RESP_W-1:0] v_words;

    assign start   = (st_q.phase == PH_IDLE) && cmd_wr && cmd_word_i[CW_START];
    assign byte_we = (st_q.phase == PH_WAIT) && rsp_byte_valid && !rsp_done;

    cr_byte_buf #(
        .LONG_BYTES (LONG_BYTES),
        .CNT_W      (CNT_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start),
        .wr_en   (byte_we),
        .wr_byte (rsp_byte),
        .cnt     (byte_cnt),
        .bytes_o (byte_img)
    );

    cr_verdict #(
        .LONG_BYTES  (LONG_BYTES),
        .SHORT_BYTES (SHORT_BYTES),
        .WORD_W      (WORD_W),
        .CNT_W       (CNT_W)
    ) u_verdict (
        .expect_rsp (st_q.cmd[CW_RESP]),
        .long_rsp   (st_q.cmd[CW_LONG]),
        .card_err   (rsp_err),
        .cnt        (byte_cnt),
        .bytes_i    (byte_img),
        .tout       (v_tout),
        .got_rsp    (v_got),
        .sent       (v_sent),
        .words_o    (v_words)
    );

    always_comb begin
        logic [STAT_W-1:0] set_bits;
        st_d     = st_q;
        set_bits = '0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (cmd_wr) begin
                    st_d.cmd = cmd_word_i;
                    st_d.arg = cmd_arg_i;
                    if (cmd_word_i[CW_START]) st_d.phase = PH_REQ;
                end
            end
            PH_REQ: begin
                st_d.phase = PH_WAIT;
            end
            PH_WAIT: begin
                if (rsp_done) begin
                    st_d.phase          = PH_IDLE;
                    st_d.cmd[CW_START]  = 1'b0;
                    set_bits[ST_TOUT]   = v_tout;
                    set_bits[ST_GOT]    = v_got;
                    set_bits[ST_SENT]   = v_sent;
                    if (v_got) st_d.resp = v_words;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
        st_d.status = (st_q.status & ~status_clr) | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy       = (st_q.phase != PH_IDLE);
    assign req_valid  = (st_q.phase == PH_REQ);
    assign req_index  = st_q.cmd[CW_IDX_W-1:0];
    assign req_arg    = st_q.arg;
    assign cmd_word_o = st_q.cmd;
    assign status     = st_q.status;
    assign resp_data  = st_q.resp;
endmodule

// File: rtl/cr_checker.sv
module cr_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_wr,
    input logic         rsp_done,
    input logic         req_valid,
    input logic         busy,
    input logic [10:0]  cmd_word_o,
    input logic [7:0]   status,
    input logic [127:0] resp_data
);
    p_req_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!req_valid && busy));

    p_req_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy);

    p_start_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cmd_word_o[10]);

    p_start_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !cmd_word_o[10]);

    p_ignore_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr && !rsp_done) |=> (cmd_word_o == $past(cmd_word_o)));

    p_status_at_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status[2]) || $rose(status[6]) || $rose(status[7])) |-> $fell(busy));

    p_lsb_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[6]) |-> !resp_data[96]);
endmodule

bind cmd_rsp_capture cr_checker u_cr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .rsp_done   (rsp_done),
    .req_valid  (req_valid),
    .busy       (busy),
    .cmd_word_o (cmd_word_o),
    .status     (status),
    .resp_data  (resp_data)
);

// File: tb/test_cmd_rsp_capture.sv
module test_cmd_rsp_capture;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_wr = 1'b0;
    logic [10:0]  cmd_word_i = '0;
    logic [31:0]  cmd_arg_i = '0;
    logic [7:0]   status_clr = '0;
    logic         req_valid;
    logic [5:0]   req_index;
    logic [31:0]  req_arg;
    logic         rsp_byte_valid = 1'b0;
    logic [7:0]   rsp_byte = '0;
    logic         rsp_done = 1'b0;
    logic         rsp_err = 1'b0;
    logic         busy;
    logic [10:0]  cmd_word_o;
    logic [7:0]   status;
    logic [127:0] resp_data;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;
    logic [7:0]   st_exp = '0;
    logic [127:0] resp_exp = '0;

    always #2 clk = ~clk;

    cmd_rsp_capture i_cmd_rsp_capture (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word_i(cmd_word_i),
        .cmd_arg_i(cmd_arg_i), .status_clr(status_clr), .req_valid(req_valid),
        .req_index(req_index), .req_arg(req_arg), .rsp_byte_valid(rsp_byte_valid),
        .rsp_byte(rsp_byte), .rsp_done(rsp_done), .rsp_err(rsp_err), .busy(busy),
        .cmd_word_o(cmd_word_o), .status(status), .resp_data(resp_data)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bval(input int seed, input int k);
        return 8'((seed * 37 + k * 11 + 5) & 255);
    endfunction

    task automatic clear_status(input logic [7:0] mask);
        @(negedge clk);
        status_clr = mask;
        @(negedge clk);
        status_clr = '0;
        st_exp = st_exp & ~mask;
        check(status == st_exp, "R12 clear", 128'(status), 128'(st_exp));
    endtask

    task automatic run_cmd(input logic [10:0] word, input logic [31:0] arg,
                           input int n, input bit err, input int seed,
                           input bit poke, input logic [7:0] clr_mask);
        bit exp_r, lng, tout;
        logic [127:0] img;
        @(negedge clk);
        cmd_wr = 1'b1; cmd_word_i = word; cmd_arg_i = arg;
        @(negedge clk);
        cmd_wr = 1'b0;
        check(busy == 1'b1, "R1 busy", 128'(busy), 128'(1));
        check(req_valid == 1'b1, "R1 req", 128'(req_valid), 128'(1));
        check(req_index == word[5:0], "R1 index", 128'(req_index), 128'(word[5:0]));
        check(req_arg == arg, "R1 arg", 128'(req_arg), 128'(arg));
        @(negedge clk);
        check(req_valid == 1'b0, "R1 one cycle", 128'(req_valid), 128'(0));
        if (poke) begin
            cmd_wr = 1'b1; cmd_word_i = 11'h4C5; cmd_arg_i = 32'hDEAD0000;
            @(negedge clk);
            cmd_wr = 1'b0;
            @(negedge clk);
            check(req_valid == 1'b0, "R11 no request", 128'(req_valid), 128'(0));
            check(cmd_word_o == word, "R11 word kept", 128'(cmd_word_o), 128'(word));
            check(req_arg == arg, "R11 arg kept", 128'(req_arg), 128'(arg));
        end
        for (int k = 0; k < n; k++) begin
            rsp_byte_valid = 1'b1;
            rsp_byte = bval(seed, k);
            @(negedge clk);
        end
        rsp_byte_valid = 1'b0;
        rsp_done = 1'b1; rsp_err = err; status_clr = clr_mask;
        @(negedge clk);
        rsp_done = 1'b0; rsp_err = 1'b0; status_clr = '0;

        exp_r = word[6];
        lng   = word[7];
        tout  = err || (exp_r && (n == 0 || (n == 4 && lng) || (n != 4 && n != 16)));
        st_exp = st_exp & ~clr_mask;
        if (tout) st_exp[2] = 1'b1;
        else if (exp_r) st_exp[6] = 1'b1;
        else st_exp[7] = 1'b1;
        if (!tout && exp_r) begin
            img = '0;
            for (int k = 0; k < n; k++) img[(k/4)*32 + 31 - 8*(k%4) -: 8] = bval(seed, k);
            if (n == 16) img[96] = 1'b0;
            resp_exp = img;
        end

        check(busy == 1'b0, "R10 busy low", 128'(busy), 128'(0));
        check(cmd_word_o == (word & 11'h3FF), "R10 start cleared",
              128'(cmd_word_o), 128'(word & 11'h3FF));
        if (err)
            check(status == st_exp, "R9 status", 128'(status), 128'(st_exp));
        else if (tout)
            check(status == st_exp, "R4 status", 128'(status), 128'(st_exp));
        else if (exp_r)
            check(status == st_exp, "R5 status", 128'(status), 128'(st_exp));
        else
            check(status == st_exp, "R3 status", 128'(status), 128'(st_exp));
        if (clr_mask != 0)
            check(status == st_exp, "R12 set wins", 128'(status), 128'(st_exp));
        if (tout || !exp_r)
            check(resp_data == resp_exp, "R3 R4 R9 response kept", resp_data, resp_exp);
        else if (n == 4)
            check(resp_data == resp_exp, "R6 R7 short packing", resp_data, resp_exp);
        else
            check(resp_data == resp_exp, "R6 R8 long packing", resp_data, resp_exp);
    endtask

    initial begin : wd
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && req_valid == 0, "reset idle", 128'({busy, req_valid}), 128'(0));
        check(status == 0 && resp_data == 0 && cmd_word_o == 0, "reset regs",
              resp_data, 128'(0));

        // R2: store without start
        @(negedge clk);
        cmd_wr = 1'b1; cmd_word_i = 11'h2D3; cmd_arg_i = 32'h12345678;
        @(negedge clk);
        cmd_wr = 1'b0;
        check(cmd_word_o == 11'h2D3, "R2 stored", 128'(cmd_word_o), 128'(11'h2D3));
        check(busy == 0 && req_valid == 0, "R2 no request", 128'({busy, req_valid}), 128'(0));
        @(negedge clk);
        check(req_valid == 0, "R2 still quiet", 128'(req_valid), 128'(0));

        // seed a non-zero response image so later unchanged checks mean something
        run_cmd(11'h5C2, 32'h0000BEEF, 16, 1'b0, 99, 1'b0, 8'h00);

        // sweep expect/long/length
        for (int e = 0; e < 2; e++) begin
            for (int l = 0; l < 2; l++) begin
                for (int n = 0; n <= 18; n++) begin
                    logic [10:0] w;
                    w = {1'b1, 2'b01, 1'(l), 1'(e), 6'((n * 3 + e * 7 + l) & 63)};
                    run_cmd(w, 32'hA5000000 + 32'(n), n, 1'b0, n * 4 + e * 2 + l,
                            1'b0, (n % 3 == 0) ? 8'hC4 : 8'h00);
                    if (n % 5 == 2) clear_status(8'h44);
                end
            end
        end

        // R9 card error
        run_cmd(11'h441, 32'h1, 4, 1'b1, 7, 1'b0, 8'hFF);
        run_cmd(11'h4C2, 32'h2, 16, 1'b1, 8, 1'b0, 8'hFF);
        run_cmd(11'h403, 32'h3, 0, 1'b1, 9, 1'b0, 8'hFF);

        // R11 writes during busy
        run_cmd(11'h44A, 32'h55AA55AA, 4, 1'b0, 11, 1'b1, 8'h00);
        run_cmd(11'h40B, 32'h0F0F0F0F, 2, 1'b0, 12, 1'b1, 8'h00);
        clear_status(8'hFF);

        ended = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule